// File: doc/BRIEF.md
# GPIO Bank Register File

A bank of up to 32 general-purpose pins, each controlled by a set of per-pin register bits reached over a simple 32-bit word bus with write strobe, read strobe and byte address. Software sets each pin's direction, the value it drives, whether that value blinks, and whether the value read back for the pin is inverted. A read-only word reports the synchronised pad levels after that inversion. The bank drives a pad output-enable vector and a pad output-value vector. It also presents two views to neighbouring logic: the polarity-adjusted input level for an interrupt block, and a per-pin logical value that follows the output register for driven pins.

Pad inputs cross into the clock domain through two flops. A free-running timebase produces a square wave whose half period is `BLINK_DIV` cycles. Any driven pin with its blink bit set outputs its data bit ANDed with that wave. When a direction write moves a pin from input to output, the same write clears that pin's blink bit.

Two small state machines set the timing. The read path uses `RD_IDLE` and `RD_RESP`. A read strobe in `RD_IDLE` moves it to `RD_RESP`. Another strobe in `RD_RESP` keeps it there, so reads can run back to back. A cycle with no strobe returns it to `RD_IDLE`. The blink timebase uses `BLK_LOW` and `BLK_HIGH`. It moves from one to the other each time its divider counter wraps at `BLINK_DIV-1`, and holds its state on every other cycle.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit is 1, so every pin is an input and pad_oe is all zeros. The output, blink and polarity words read as zero.
- R2: Direction lives at byte address 0x04. A bit of 1 makes the pin an input with pad_oe low. A bit of 0 drives pad_oe high from the cycle after the write.
- R3: Output data lives at byte address 0x00 and reads back as written. A driven pin with its blink bit clear puts its data bit on pad_out.
- R4: Input data at byte address 0x10 returns the pad level after two synchroniser flops, XORed with the polarity word at byte address 0x0C. A polarity bit of 1 inverts that pin. in_level carries the same value. With reads on three consecutive edges starting at the first edge after a pad change, the first two return the old level and the third returns the new one.
- R5: pin_value gives the output data bit for a pin whose direction bit is 0. For a pin whose direction bit is 1 it gives the polarity-adjusted input, and polarity does not affect driven pins.
- R6: For a driven pin with its blink bit (byte address 0x08) set, pad_out is its data bit ANDed with a square wave that is high BLINK_DIV cycles out of every 2*BLINK_DIV. A blinking pin with data 0 stays low. Blink bits on input pins leave pad_oe low.
- R7: A direction write clears the blink bit of each pin it moves from 1 to 0. Blink bits of pins that were already driven, or that stay inputs, are kept.
- R8: A read strobe produces rdata with rvalid high in the following cycle. Reads on consecutive cycles each produce one result, in order.
- R9: Writes to the input data address have no effect on any register.
- R10: Reads from any address other than the five mapped ones, misaligned addresses included, return zero. Writes to such addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read result valid, one cycle after rd_en |
| pad_in | input | NPINS | Raw pad input levels |
| pad_oe | output | NPINS | Pad driver enable, 1 = driving |
| pad_out | output | NPINS | Pad driven value after blink gating |
| in_level | output | NPINS | Synchronised input XOR polarity, for interrupt logic |
| pin_value | output | NPINS | Logical pin value: output data when driven, input otherwise |

## Verification
The bench changes a pad and reads it on three back-to-back edges. A synchroniser that is one flop short, or a read path that adds or drops a register, shows up as the new value arriving one read early or late. It writes direction words that move some blink-enabled pins to output while others are already driven or stay inputs. Clearing every blink bit, or none, gives the wrong blink word on readback. It counts pad_out highs over full blink periods for a blinking pin, a steady pin and a blinking pin with data 0. A divider off by one, or gating applied to the wrong pins, gives the wrong counts. Writes to the read-only and unmapped addresses are each followed by a readback of every register, so a decoder that aliases those addresses onto a real register is caught.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W = 32;

    localparam int OFF_OUT   = 'h00;
    localparam int OFF_DIR   = 'h04;
    localparam int OFF_BLINK = 'h08;
    localparam int OFF_POL   = 'h0C;
    localparam int OFF_IN    = 'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OUT,
        SEL_DIR,
        SEL_BLINK,
        SEL_POL,
        SEL_IN
    } reg_sel_t;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_t;

    typedef enum logic {
        BLK_LOW,
        BLK_HIGH
    } blink_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;

endmodule

// File: rtl/gpio_blink.sv
module gpio_blink
    import gpio_pkg::*;
#(
    parameter int BLINK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic wave
);

    localparam int CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BLINK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    blink_state_t     ph_q;
    blink_state_t     ph_next;

    assign wrap = (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= BLK_LOW;
        end else begin
            ph_q <= ph_next;
        end
    end

    // next state: flip on divider wrap
    always_comb begin
        ph_next = ph_q;
        unique case (ph_q)
            BLK_LOW:  if (wrap) ph_next = BLK_HIGH;
            BLK_HIGH: if (wrap) ph_next = BLK_LOW;
        endcase
    end

    // output decode
    always_comb begin
        unique case (ph_q)
            BLK_LOW:  wave = 1'b0;
            BLK_HIGH: wave = 1'b1;
        endcase
    end

    // R6: the phase holds between wraps and flips on each wrap
    a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(ph_q));
    a_r6_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (ph_q != $past(ph_q)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPINS-1:0]  in_view,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  blink_q,
    output logic [NPINS-1:0]  pol_q
);

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s = SEL_NONE;
        if (a == ADDR_W'(OFF_OUT))   s = SEL_OUT;
        if (a == ADDR_W'(OFF_DIR))   s = SEL_DIR;
        if (a == ADDR_W'(OFF_BLINK)) s = SEL_BLINK;
        if (a == ADDR_W'(OFF_POL))   s = SEL_POL;
        if (a == ADDR_W'(OFF_IN))    s = SEL_IN;
        return s;
    endfunction

    reg_sel_t          sel;
    logic [NPINS-1:0]  wpins;
    logic [NPINS-1:0]  newly_out;
    logic [NPINS-1:0]  rd_pins;
    logic [DATA_W-1:0] rd_word;
    rd_state_t         rd_state;
    rd_state_t         rd_next;

    assign sel       = decode(addr);
    assign wpins     = wdata[NPINS-1:0];
    assign newly_out = dir_q & ~wpins;

    // register storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_OUT:   out_q   <= wpins;
                SEL_DIR: begin
                    dir_q   <= wpins;
                    blink_q <= blink_q & ~newly_out;
                end
                SEL_BLINK: blink_q <= wpins;
                SEL_POL:   pol_q   <= wpins;
                SEL_IN:    ;
                SEL_NONE:  ;
            endcase
        end
    end

    // read multiplexer
    always_comb begin
        rd_pins = '0;
        unique case (sel)
            SEL_OUT:   rd_pins = out_q;
            SEL_DIR:   rd_pins = dir_q;
            SEL_BLINK: rd_pins = blink_q;
            SEL_POL:   rd_pins = pol_q;
            SEL_IN:    rd_pins = in_view;
            SEL_NONE:  rd_pins = '0;
        endcase
        rd_word = '0;
        rd_word[NPINS-1:0] = rd_pins;
    end

    // read response state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_state <= RD_IDLE;
        end else begin
            rd_state <= rd_next;
        end
    end

    always_comb begin
        rd_next = rd_state;
        unique case (rd_state)
            RD_IDLE: rd_next = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: rd_next = rd_en ? RD_RESP : RD_IDLE;
        endcase
    end

    // read response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_word;
        end
    end

    assign rvalid = (rd_state == RD_RESP);

    // R7: pins moved to output by a direction write have no blink bit afterwards
    a_r7_blink_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DIR) |=> ((blink_q & ~dir_q & $past(dir_q)) == '0));

    // R8: every read strobe is answered in the next cycle
    a_r8_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    // R9: a write to the input data word changes no register
    a_r9_in_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_IN) |=>
        ($stable(out_q) && $stable(dir_q) && $stable(blink_q) && $stable(pol_q)));

    // R10: unmapped writes change no register, unmapped reads return zero
    a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=>
        ($stable(out_q) && $stable(dir_q) && $stable(blink_q) && $stable(pol_q)));
    a_r10_unmapped_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rdata == '0));

endmodule

// File: rtl/gpio_pad.sv
module gpio_pad #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] out_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] blink_q,
    input  logic [NPINS-1:0] in_view,
    input  logic             wave,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pin_value
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign pad_oe[i]    = ~dir_q[i];
        assign pad_out[i]   = out_q[i] & (~blink_q[i] | wave);
        assign pin_value[i] = dir_q[i] ? in_view[i] : out_q[i];
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int ADDR_W    = 8,
    parameter int BLINK_DIV = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  in_level,
    output logic [NPINS-1:0]  pin_value
);

    logic [NPINS-1:0] sync_in;
    logic [NPINS-1:0] in_view;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] blink_q;
    logic [NPINS-1:0] pol_q;
    logic             wave;

    gpio_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_in)
    );

    assign in_view  = sync_in ^ pol_q;
    assign in_level = in_view;

    gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .in_view (in_view),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .blink_q (blink_q),
        .pol_q   (pol_q)
    );

    gpio_blink #(.BLINK_DIV(BLINK_DIV)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .wave  (wave)
    );

    gpio_pad #(.NPINS(NPINS)) u_pad (
        .out_q     (out_q),
        .dir_q     (dir_q),
        .blink_q   (blink_q),
        .in_view   (in_view),
        .wave      (wave),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pin_value (pin_value)
    );

    // R2: a direction write sets pad drivers to the complement of the written bits
    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_DIR)) |=> (pad_oe == ~$past(wdata[NPINS-1:0])));

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NP   = 32;
    localparam int AW   = 8;
    localparam int BDIV = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] in_level;
    logic [NP-1:0] pin_value;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.NPINS(NP), .ADDR_W(AW), .BLINK_DIV(BDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .in_level(in_level),
        .pin_value(pin_value)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected read result actual=%h expected=none", rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, rdata, e.exp);
            end
        end
    end

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; addr = AW'(a); wdata = d;
    endtask

    task automatic bus_rd(input int a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = AW'(a);
        it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic bus_idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic drain();
        bus_idle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe after reset", pad_oe, 32'h0);
        chk("R1 pad_out after reset", pad_out, 32'h0);
        bus_rd('h00, 32'h0, "R1 output word reset");
        bus_rd('h04, 32'hFFFF_FFFF, "R1 direction word reset");
        bus_rd('h08, 32'h0, "R1 blink word reset");
        bus_rd('h0C, 32'h0, "R1 polarity word reset");
        drain();

        // R3 output data and R2 all driven
        bus_wr('h00, 32'h1234_5678);
        bus_wr('h04, 32'h0000_0000);
        bus_idle();
        chk("R2 all pins driven", pad_oe, 32'hFFFF_FFFF);
        chk("R3 pad_out follows output word", pad_out, 32'h1234_5678);
        bus_rd('h00, 32'h1234_5678, "R3 output word readback");
        bus_rd('h04, 32'h0, "R2 direction readback");
        drain();

        // R2 split direction
        bus_wr('h04, 32'hFFFF_0000);
        bus_idle();
        chk("R2 upper half inputs", pad_oe, 32'h0000_FFFF);

        // R5 and R4 with pad data
        pad_in = 32'hABCD_9999;
        repeat (3) @(negedge clk);
        chk("R5 pin_value mix", pin_value, 32'hABCD_5678);
        bus_wr('h0C, 32'hFF00_00FF);
        bus_idle();
        chk("R5 pin_value with polarity", pin_value, 32'h54CD_5678);
        chk("R4 in_level with polarity", in_level, 32'h54CD_9966);
        bus_rd('h10, 32'h54CD_9966, "R4 input word with polarity");
        drain();

        // R4 synchroniser depth and R8 back-to-back reads
        @(negedge clk);
        pad_in = 32'h0F0F_F0F0;
        wr_en = 1'b0; rd_en = 1'b1; addr = AW'('h10);
        sb.push_back('{exp: 32'h54CD_9966, tag: "R4 first read after change old"});
        @(negedge clk);
        sb.push_back('{exp: 32'h54CD_9966, tag: "R4 second read after change old"});
        @(negedge clk);
        sb.push_back('{exp: 32'hF00F_F00F, tag: "R4 third read after change new"});
        drain();

        // R9 input word is read-only
        bus_wr('h10, 32'hDEAD_BEEF);
        bus_rd('h00, 32'h1234_5678, "R9 output word kept");
        bus_rd('h04, 32'hFFFF_0000, "R9 direction word kept");
        bus_rd('h08, 32'h0, "R9 blink word kept");
        bus_rd('h0C, 32'hFF00_00FF, "R9 polarity word kept");
        bus_rd('h10, 32'hF00F_F00F, "R9 input word unchanged");
        drain();

        // R10 unmapped addresses
        bus_wr('h14, 32'hFFFF_FFFF);
        bus_wr('h01, 32'hFFFF_FFFF);
        bus_wr('h20, 32'hFFFF_FFFF);
        bus_rd('h14, 32'h0, "R10 read 0x14");
        bus_rd('h02, 32'h0, "R10 read misaligned");
        bus_rd('h18, 32'h0, "R10 read 0x18");
        bus_rd('h00, 32'h1234_5678, "R10 output word kept");
        bus_rd('h04, 32'hFFFF_0000, "R10 direction word kept");
        bus_rd('h0C, 32'hFF00_00FF, "R10 polarity word kept");
        drain();

        // R7 blink clear on input-to-output transitions only
        bus_wr('h04, 32'hFFFF_FFFF);
        bus_wr('h08, 32'h0000_000F);
        bus_wr('h04, 32'hFFFF_FFFC);
        bus_rd('h08, 32'h0000_000C, "R7 pins 0 1 cleared");
        bus_wr('h08, 32'h0000_000F);
        bus_wr('h04, 32'hFFFF_FFF0);
        bus_rd('h08, 32'h0000_0003, "R7 already driven pins kept");
        bus_wr('h04, 32'hFFFF_FFFF);
        bus_rd('h08, 32'h0000_0003, "R7 output to input keeps blink");
        drain();

        // R6 blink gating
        bus_wr('h04, 32'hFFFF_FF8F);
        bus_wr('h00, 32'h0000_0030);
        bus_wr('h08, 32'h0000_0053);
        bus_idle();
        chk("R6 blink on inputs leaves oe low", pad_oe, 32'h0000_0070);
        for (int w = 0; w < 2; w++) begin
            int c4, c5, c6;
            c4 = 0; c5 = 0; c6 = 0;
            for (int k = 0; k < 2*BDIV; k++) begin
                @(negedge clk);
                c4 += int'(pad_out[4]);
                c5 += int'(pad_out[5]);
                c6 += int'(pad_out[6]);
            end
            chk("R6 blinking pin high count", 32'(c4), 32'(BDIV));
            chk("R3 steady pin high count", 32'(c5), 32'(2*BDIV));
            chk("R6 blinking zero pin high count", 32'(c6), 32'h0);
        end

        drain();
        chk("R8 all reads answered", 32'(sb.size()), 32'h0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule